// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches one received Ethernet frame at a time, delivered as a byte stream. A start strobe opens the frame and a valid strobe accompanies each byte. An end strobe closes the frame and carries two qualifiers from the receive path: one says the frame check sequence was good, the other says the destination address passed the filter. The block searches the frame for the wake pattern. The pattern is a run of at least six 0xFF bytes followed at once by sixteen back-to-back copies of the 6-byte station ID. It may start at any byte offset.

A pattern found inside the frame is only held until the frame ends. It turns into a wake event only if the frame ends good and both the magic-enable and the power-event-enable bits are set. The event sets a sticky power-event status bit. Software clears that bit with a write-1 strobe. The active-low wake output is driven while the status bit is set and the configuration-space power-event enable is 1. The MAC, CRC computation and address filtering are outside this block.

Top module: `magic_wake_det`

## Requirements
- R1: After synchronous reset, `pme_status` is 0 and `wake_n` is 1.
- R2: A frame holding six 0xFF bytes followed by sixteen consecutive copies of the station ID, at any byte offset, sets `pme_status` on the clock edge that samples `rx_eof` with `rx_crc_ok`=1 and `rx_addr_ok`=1, and with `magic_en`=`pme_en`=1. `rx_sof` and `rx_eof` are strobes in cycles of their own, without a data byte.
- R3: A synchronisation run longer than six 0xFF bytes, directly followed by the sixteen ID copies, is accepted.
- R4: Fewer than six 0xFF bytes before the copies, or fewer than sixteen copies, gives no wake.
- R5: A byte that breaks the ID copies restarts the search. A run of 0xFF bytes that begins at that break byte counts toward a new synchronisation run.
- R6: A frame that ends with `rx_crc_ok`=0 or `rx_addr_ok`=0 does not set `pme_status`, even when it holds the pattern.
- R7: With `magic_en`=0 or `pme_en`=0 at frame end, `pme_status` is not set.
- R8: `rx_sof` discards any match held from the previous frame. A frame that is aborted by a new `rx_sof` cannot cause a wake at the later `rx_eof`.
- R9: `pme_status` stays 1 across later frames and idle cycles until a cycle with `pme_clr`=1 clears it on the next edge. A wake event in the same cycle as the clear wins.
- R10: `wake_n` is 0 exactly when `pme_status`=1 and `cfg_pme_en`=1, and 1 otherwise.
- R11: The station ID is compared in transmission order. `station_id[47:40]` is the first byte of each copy and `station_id[7:0]` is the last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sof | input | 1 | Frame start strobe (no data in this cycle) |
| rx_vld | input | 1 | Data byte valid |
| rx_data | input | 8 | Received data byte |
| rx_eof | input | 1 | Frame end strobe (no data in this cycle) |
| rx_crc_ok | input | 1 | Frame check sequence good, sampled with rx_eof |
| rx_addr_ok | input | 1 | Destination address accepted, sampled with rx_eof |
| station_id | input | 48 | Static station ID, first transmitted byte in bits 47:40 |
| magic_en | input | 1 | Magic-frame wake enable |
| pme_en | input | 1 | Power-event enable |
| cfg_pme_en | input | 1 | Configuration-space power-event enable, gates the output |
| pme_clr | input | 1 | Write-1-to-clear strobe for the status |
| pme_status | output | 1 | Sticky power-event status |
| wake_n | output | 1 | Active-low wake indication |

## Verification
Directed frames place the pattern at offset zero and at a deep offset. They stretch and shorten the 0xFF run and cut the copy count to fifteen, which separates the exact length rules from a loose search. A run broken partway, where the break byte itself starts a fresh 0xFF run, shows whether the restart keeps that run. A byte-reversed ID shows whether the comparison order is right. Bad-CRC, rejected-address, disabled-enable and aborted frames each carry a valid pattern, so a wake in any of them points to a missing gate. Random frames built from 0xFF, ID bytes and noise, some with planted and corrupted patterns, are compared against a bench search that looks for the pattern at every offset.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

    localparam int ID_BYTES = 6;
    localparam int ID_W     = 8 * ID_BYTES;

    typedef enum logic [0:0] {
        PH_SEEK = 1'b0,
        PH_ID   = 1'b1
    } scan_phase_e;

    typedef struct packed {
        logic       start;
        logic       vld;
        logic [7:0] data;
    } rx_beat_t;

    typedef struct packed {
        logic end_stb;
        logic crc_ok;
        logic addr_ok;
    } rx_close_t;

    function automatic logic [7:0] id_byte(input logic [ID_W-1:0] id, input logic [31:0] k);
        return id[ID_W-1-8*k -: 8];
    endfunction

endpackage

// File: rtl/mwd_scanner.sv
module mwd_scanner
    import mwd_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int ID_REPS  = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  rx_beat_t        beat,
    input  logic [ID_W-1:0] sid,
    output logic            found
);

    localparam int FF_W  = $clog2(SYNC_LEN + 1);
    localparam int IDX_W = $clog2(ID_BYTES);
    localparam int REP_W = $clog2(ID_REPS);
    localparam logic [FF_W-1:0]  FF_FULL  = FF_W'(SYNC_LEN);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_BYTES - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(ID_REPS - 1);

    scan_phase_e      ph_q, ph_d;
    logic [FF_W-1:0]  ffc_q, ffc_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [REP_W-1:0] rep_q, rep_d;
    logic             found_q, found_d;
    logic             is_ff;

    assign is_ff = (beat.data == 8'hFF);

    always_comb begin
        ph_d    = ph_q;
        ffc_d   = ffc_q;
        idx_d   = idx_q;
        rep_d   = rep_q;
        found_d = found_q;
        if (beat.start) begin
            ph_d    = PH_SEEK;
            ffc_d   = '0;
            idx_d   = '0;
            rep_d   = '0;
            found_d = 1'b0;
        end else if (beat.vld && !found_q) begin
            // running count of consecutive 0xFF bytes, saturating at the sync length
            ffc_d = is_ff ? ((ffc_q == FF_FULL) ? ffc_q : ffc_q + 1'b1) : '0;
            unique case (ph_q)
                PH_SEEK: begin
                    if (ffc_q == FF_FULL && beat.data == id_byte(sid, 32'd0)) begin
                        ph_d  = PH_ID;
                        idx_d = IDX_W'(1);
                        rep_d = '0;
                    end
                end
                PH_ID: begin
                    if (beat.data == id_byte(sid, 32'(idx_q))) begin
                        if (idx_q == IDX_LAST) begin
                            idx_d = '0;
                            if (rep_q == REP_LAST) begin
                                found_d = 1'b1;
                                ph_d    = PH_SEEK;
                            end else begin
                                rep_d = rep_q + 1'b1;
                            end
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end else begin
                        // break: back to searching, the 0xFF count above keeps the trailing run
                        ph_d  = PH_SEEK;
                        idx_d = '0;
                        rep_d = '0;
                    end
                end
                default: ph_d = PH_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_SEEK;
            ffc_q   <= '0;
            idx_q   <= '0;
            rep_q   <= '0;
            found_q <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            ffc_q   <= ffc_d;
            idx_q   <= idx_d;
            rep_q   <= rep_d;
            found_q <= found_d;
        end
    end

    assign found = found_q;

    // R8: a frame start drops any held match
    p_start_drops_match_r8: assert property (@(posedge clk) disable iff (rst)
        beat.start |=> !found);

    // R2: a held match survives until the next frame start
    p_match_held_r2: assert property (@(posedge clk) disable iff (rst)
        (found && !beat.start) |=> found);

    // R4: a match appears only after a data byte
    p_match_on_byte_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(found) |-> $past(beat.vld));

endmodule

// File: rtl/mwd_pme_ctrl.sv
module mwd_pme_ctrl
    import mwd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_close_t close,
    input  logic      found,
    input  logic      magic_en,
    input  logic      pme_en,
    input  logic      cfg_pme_en,
    input  logic      pme_clr,
    output logic      pme_status,
    output logic      wake_n
);

    logic commit;
    logic status_q;

    assign commit = close.end_stb && close.crc_ok && close.addr_ok
                    && found && magic_en && pme_en;

    always_ff @(posedge clk) begin
        if (rst)          status_q <= 1'b0;
        else if (commit)  status_q <= 1'b1;
        else if (pme_clr) status_q <= 1'b0;
    end

    assign pme_status = status_q;
    assign wake_n     = !(status_q && cfg_pme_en);

    // R6: status rises only after a good frame end
    p_set_on_good_end_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pme_status) |-> $past(close.end_stb && close.crc_ok && close.addr_ok));

    // R7: status rises only with both enables set
    p_set_needs_enables_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pme_status) |-> $past(magic_en && pme_en));

    // R9: a clear strobe with no frame end empties the status
    p_clear_works_r9: assert property (@(posedge clk) disable iff (rst)
        (pme_clr && !close.end_stb) |=> !pme_status);

    // R9: status is sticky without a clear
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (pme_status && !pme_clr) |=> pme_status);

endmodule

// File: rtl/magic_wake_det.sv
module magic_wake_det
    import mwd_pkg::*;
#(
    parameter int SYNC_LEN = 6,
    parameter int ID_REPS  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rx_sof,
    input  logic                     rx_vld,
    input  logic [7:0]               rx_data,
    input  logic                     rx_eof,
    input  logic                     rx_crc_ok,
    input  logic                     rx_addr_ok,
    input  logic [mwd_pkg::ID_W-1:0] station_id,
    input  logic                     magic_en,
    input  logic                     pme_en,
    input  logic                     cfg_pme_en,
    input  logic                     pme_clr,
    output logic                     pme_status,
    output logic                     wake_n
);

    rx_beat_t  beat;
    rx_close_t close;
    logic      found;

    assign beat  = '{start: rx_sof, vld: rx_vld, data: rx_data};
    assign close = '{end_stb: rx_eof, crc_ok: rx_crc_ok, addr_ok: rx_addr_ok};

    mwd_scanner #(
        .SYNC_LEN (SYNC_LEN),
        .ID_REPS  (ID_REPS)
    ) u_scan (
        .clk   (clk),
        .rst   (rst),
        .beat  (beat),
        .sid   (station_id),
        .found (found)
    );

    mwd_pme_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .close      (close),
        .found      (found),
        .magic_en   (magic_en),
        .pme_en     (pme_en),
        .cfg_pme_en (cfg_pme_en),
        .pme_clr    (pme_clr),
        .pme_status (pme_status),
        .wake_n     (wake_n)
    );

    // R10: wake is driven only while the status is held and the output is enabled
    p_wake_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !wake_n |-> (pme_status && cfg_pme_en));

endmodule

// File: tb/tb_magic_wake_det.sv
module tb_magic_wake_det;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_sof, rx_vld, rx_eof, rx_crc_ok, rx_addr_ok;
    logic [7:0]  rx_data;
    logic [47:0] station_id;
    logic        magic_en, pme_en, cfg_pme_en, pme_clr;
    logic        pme_status, wake_n;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic exp_st   = 1'b0;
    logic [7:0] fq[$];

    always #4 clk = ~clk;

    magic_wake_det dut (
        .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok), .rx_addr_ok(rx_addr_ok),
        .station_id(station_id), .magic_en(magic_en), .pme_en(pme_en),
        .cfg_pme_en(cfg_pme_en), .pme_clr(pme_clr), .pme_status(pme_status), .wake_n(wake_n)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] idb(input logic [47:0] id, input int k);
        return id[47-8*k -: 8];
    endfunction

    // bench search: six 0xFF then sixteen ID copies at any offset
    function automatic bit has_pattern(input logic [47:0] id);
        for (int i = 0; i + 102 <= fq.size(); i++) begin
            bit ok = 1'b1;
            for (int j = 0; j < 6; j++) if (fq[i+j] != 8'hFF) ok = 1'b0;
            for (int j = 0; j < 96; j++) if (fq[i+6+j] != idb(id, j % 6)) ok = 1'b0;
            if (ok) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic add_pattern(input int nff, input int reps, input logic [47:0] id);
        for (int i = 0; i < nff; i++) fq.push_back(8'hFF);
        for (int i = 0; i < reps * 6; i++) fq.push_back(idb(id, i % 6));
    endtask

    task automatic add_noise(input int n, input logic [47:0] id);
        for (int i = 0; i < n; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 4)      fq.push_back(8'hFF);
            else if (r < 8) fq.push_back(idb(id, $urandom_range(0, 5)));
            else            fq.push_back(8'($urandom_range(0, 255)));
        end
    endtask

    task automatic send_bytes();
        foreach (fq[i]) begin
            rx_vld = 1'b1; rx_data = fq[i];
            tick();
        end
        rx_vld = 1'b0; rx_data = 8'h00;
    endtask

    // sends fq as one frame and checks status and wake one cycle after the end strobe
    task automatic run_frame(input string req, input logic crc, input logic addr);
        bit m = has_pattern(station_id);
        rx_sof = 1'b1; tick(); rx_sof = 1'b0;
        send_bytes();
        rx_eof = 1'b1; rx_crc_ok = crc; rx_addr_ok = addr;
        tick();
        rx_eof = 1'b0; rx_crc_ok = 1'b0; rx_addr_ok = 1'b0;
        if (m && crc && addr && magic_en && pme_en) exp_st = 1'b1;
        check(req, pme_status, exp_st);
        check(req, wake_n, !(exp_st && cfg_pme_en));
        fq.delete();
    endtask

    task automatic clear_status();
        pme_clr = 1'b1; tick(); pme_clr = 1'b0;
        exp_st = 1'b0;
        check("R9 clear", pme_status, 1'b0);
        check("R10 clear", wake_n, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; rx_sof = 0; rx_vld = 0; rx_data = 0; rx_eof = 0;
        rx_crc_ok = 0; rx_addr_ok = 0; pme_clr = 0;
        station_id = 48'h021A3B4C5D6E;
        magic_en = 1; pme_en = 1; cfg_pme_en = 1;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 status", pme_status, 1'b0);
        check("R1 wake", wake_n, 1'b1);

        // R2 offset zero, then sticky across idle and a plain frame
        add_pattern(6, 16, station_id);
        run_frame("R2 offset0", 1, 1);
        repeat (5) tick();
        check("R9 sticky idle", pme_status, 1'b1);
        add_noise(30, station_id);
        run_frame("R9 sticky frame", 1, 1);
        clear_status();

        // R2 deep offset
        for (int i = 0; i < 37; i++) fq.push_back(8'(i * 7 + 1));
        add_pattern(6, 16, station_id);
        add_noise(10, station_id);
        run_frame("R2 offset37", 1, 1);
        check("R2 offset37 set", exp_st, 1'b1);
        clear_status();

        // R3 long sync run
        fq.push_back(8'h11);
        add_pattern(9, 16, station_id);
        run_frame("R3 long sync", 1, 1);
        clear_status();

        // R4 short sync and short repeat count
        fq.push_back(8'h11);
        add_pattern(5, 16, station_id);
        run_frame("R4 five ff", 1, 1);
        add_pattern(6, 15, station_id);
        fq.push_back(8'h22);
        run_frame("R4 fifteen reps", 1, 1);

        // R5 break byte starts a new sync run
        add_pattern(6, 3, station_id);
        for (int i = 0; i < 3; i++) fq.push_back(idb(station_id, i));
        add_pattern(6, 16, station_id);
        run_frame("R5 restart", 1, 1);
        check("R5 restart set", exp_st, 1'b1);
        clear_status();

        // R6 bad crc, bad address
        add_pattern(6, 16, station_id);
        run_frame("R6 bad crc", 0, 1);
        add_pattern(6, 16, station_id);
        run_frame("R6 bad addr", 1, 0);

        // R7 enables
        magic_en = 0;
        add_pattern(6, 16, station_id);
        run_frame("R7 magic off", 1, 1);
        magic_en = 1; pme_en = 0;
        add_pattern(6, 16, station_id);
        run_frame("R7 pme off", 1, 1);
        pme_en = 1;

        // R8 aborted frame: pattern, new start, junk, good end
        add_pattern(6, 16, station_id);
        rx_sof = 1'b1; tick(); rx_sof = 1'b0;
        send_bytes();
        fq.delete();
        add_noise(12, 48'h0);
        run_frame("R8 abort", 1, 1);

        // R10 output gate
        cfg_pme_en = 0;
        add_pattern(6, 16, station_id);
        run_frame("R10 gated", 1, 1);
        check("R10 gated wake", wake_n, 1'b1);
        cfg_pme_en = 1; tick();
        check("R10 enabled wake", wake_n, 1'b0);
        // R9 clear and set in the same cycle: set wins
        add_pattern(6, 16, station_id);
        rx_sof = 1'b1; tick(); rx_sof = 1'b0;
        send_bytes(); fq.delete();
        rx_eof = 1; rx_crc_ok = 1; rx_addr_ok = 1; pme_clr = 1;
        tick();
        rx_eof = 0; rx_crc_ok = 0; rx_addr_ok = 0; pme_clr = 0;
        check("R9 set beats clear", pme_status, 1'b1);
        clear_status();

        // R11 reversed byte order gives no wake
        add_pattern(6, 16, {station_id[7:0], station_id[15:8], station_id[23:16],
                            station_id[31:24], station_id[39:32], station_id[47:40]});
        run_frame("R11 reversed", 1, 1);

        // random frames
        for (int f = 0; f < 160; f++) begin
            logic crc  = ($urandom_range(0, 9) != 0);
            logic addr = ($urandom_range(0, 9) != 0);
            for (int k = 0; k < 6; k++) station_id[47-8*k -: 8] = 8'($urandom_range(0, 254));
            add_noise($urandom_range(0, 40), station_id);
            if ($urandom_range(0, 1) == 1) begin
                add_pattern($urandom_range(5, 8), $urandom_range(15, 16), station_id);
                if ($urandom_range(0, 3) == 0) fq[$urandom_range(0, fq.size() - 1)] = 8'h00;
            end
            add_noise($urandom_range(0, 20), station_id);
            run_frame("R2 random", crc, addr);
            if (exp_st) clear_status();
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule